// File: doc/BRIEF.md
# QAM Baseband Modulator

This block turns a serial bit stream into digital passband samples of a square 16-point quadrature amplitude modulation. Input bits are collected in groups of four. Each group selects one constellation point: two Gray-coded bits give the in-phase level and two give the quadrature level. Both axes are interpolated by SPS samples per symbol through identical polyphase pulse-shaping filters. The shaped in-phase branch is then multiplied by a digital cosine and the quadrature branch by a digital sine, and the two products are added.

The carrier comes from a phase accumulator that drives a quarter-wave sine table. The sum is rounded, saturated to 16 bits and registered. The output runs at one sample per clock, so the clock sets the sample rate. Bits arrive on a valid/ready handshake. The block applies backpressure only when a finished word is still waiting for its symbol slot. When no new word is ready, the block inserts zero-valued symbols.

Top module: `qam_mod_tx`

## Requirements
- R1: A bit is taken on a rising edge where both bit_valid_i and bit_ready_o are high. Every four taken bits form one word. The first and second taken bits are the in-phase pair, with the first bit as MSB. The third and fourth taken bits are the quadrature pair, with the third bit as MSB.
- R2: Each pair maps to a level with Gray coding: 00 gives -3, 01 gives -1, 11 gives +1 and 10 gives +3.
- R3: Edges are counted from 1, the first edge after reset release. Symbol boundaries are edges whose count is a multiple of SPS (default 8). At a boundary, a completed word that is not yet used becomes the newest symbol, provided it was completed at an earlier edge. If there is no such word, a zero symbol enters on both axes.
- R4: At cycle phase p = edge count mod SPS, each axis is shaped as sum over j of g[j*SPS+p]*s[n-j], for j = 0 to NSYM-1. Here s[n] is the newest symbol and g[k] = min(k+1, SPS*NSYM-k). With the defaults this gives 1..8, 8..1.
- R5: The carrier phase starts at zero and advances by PHASE_INC each edge. The sine and cosine have peak 32767. With PHASE_INC = 16384, at edge count mod 4 = 0, 1, 2, 3 the cosine is 32767, 0, -32767, 0 and the sine is 0, 32767, 0, -32767.
- R6: Let v = I_shaped*cos + Q_shaped*sin, computed from the state after edge e. The sample registered at edge e+1 is floor((v+4)/8).
- R7: Results above 32767 are clamped to 32767, and results below -32768 are clamped to -32768.
- R8: bit_ready_o is low only when three bits of a word are held, a completed word is waiting, and the next edge is not a boundary. No bit is ever lost.
- R9: While reset is asserted, sample_o is 0 and bit_ready_o is 1. Reset discards partial bits, waiting words, symbols and carrier phase.
- R10: sample_o is 0 until the first completed word has entered the filters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Input bit is valid |
| bit_i | input | 1 | Input bit |
| bit_ready_o | output | 1 | Block accepts a bit this cycle |
| sample_o | output | OUT_W | Signed passband sample |

## Verification
The bound checker checks the handshake on every cycle. Ready may drop only on the fourth bit of a word, and it never stays low for a full symbol period. The checker also confirms that the output stays zero before the first word and after a long input drought. The exact sample values need the bench's own model of the constellation, filter taps, carrier and rounding, run under scenarios with gaps, back-to-back words, saturating symbols and a reset in mid-word. The symbol timing also needs these scenarios.

// File: rtl/qam_tx_pkg.sv
`timescale 1ns/1ps
package qam_tx_pkg;
  localparam int BITS_PER_SYM = 4;
  localparam int LVL_W = 3;

  // Gray-coded axis level
  function automatic logic signed [LVL_W-1:0] axis_level(input logic [1:0] pair);
    case (pair)
      2'b00:   axis_level = -3'sd3;
      2'b01:   axis_level = -3'sd1;
      2'b11:   axis_level = 3'sd1;
      default: axis_level = 3'sd3;
    endcase
  endfunction

  // Triangular pulse tap
  function automatic int shape_tap(input int k, input int sps, input int nsym);
    int up, dn;
    up = k + 1;
    dn = sps * nsym - k;
    return (up < dn) ? up : dn;
  endfunction
endpackage

// File: rtl/qam_bit_packer.sv
`timescale 1ns/1ps
module qam_bit_packer #(
  parameter int J = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_valid_i,
  input  logic         bit_i,
  output logic         bit_ready_o,
  input  logic         sym_tick_i,
  output logic [J-1:0] word_o,
  output logic         word_valid_o
);
  localparam int CNTW = $clog2(J);

  logic [CNTW-1:0] cnt_q;
  logic [J-2:0]    shreg_q;
  logic [J-1:0]    pend_q;
  logic            pend_valid_q;
  logic            take;

  assign bit_ready_o = !((cnt_q == CNTW'(J-1)) && pend_valid_q && !sym_tick_i);
  assign take        = bit_valid_i && bit_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      shreg_q      <= '0;
      pend_q       <= '0;
      pend_valid_q <= 1'b0;
    end else begin
      if (sym_tick_i) pend_valid_q <= 1'b0;
      if (take) begin
        if (cnt_q == CNTW'(J-1)) begin
          cnt_q        <= '0;
          pend_q       <= {shreg_q, bit_i};
          pend_valid_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          shreg_q <= {shreg_q[J-3:0], bit_i};
        end
      end
    end
  end

  assign word_o       = pend_q;
  assign word_valid_o = pend_valid_q;
endmodule

// File: rtl/qam_quarter_sine.sv
`timescale 1ns/1ps
module qam_quarter_sine #(
  parameter int QB = 6,
  parameter int CW = 16
) (
  input  logic [QB+1:0]        phase_i,
  output logic signed [CW-1:0] val_o
);
  localparam int QN  = 1 << QB;
  localparam int AMP = (1 << (CW-1)) - 1;

  logic signed [CW-1:0] tbl [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_tbl
    localparam real ANG = 3.14159265358979 * k / (2.0 * QN);
    localparam int  V   = int'($floor(AMP * $sin(ANG) + 0.5));
    assign tbl[k] = V[CW-1:0];
  end

  logic [1:0]           quad;
  logic [QB:0]          idx, ridx;
  logic signed [CW-1:0] mag;

  always_comb begin
    quad  = phase_i[QB+1:QB];
    idx   = {1'b0, phase_i[QB-1:0]};
    ridx  = (QB+1)'(QN) - idx;
    mag   = quad[0] ? tbl[ridx] : tbl[idx];
    val_o = quad[1] ? -mag : mag;
  end
endmodule

// File: rtl/qam_polyphase_fir.sv
`timescale 1ns/1ps
module qam_polyphase_fir
  import qam_tx_pkg::*;
#(
  parameter int SPS  = 8,
  parameter int NSYM = 2,
  parameter int SW   = 3,
  parameter int OW   = 9,
  localparam int PHW = $clog2(SPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic signed [SW-1:0] sym_i,
  input  logic [PHW-1:0]       ph_i,
  output logic signed [OW-1:0] shaped_o
);
  logic signed [SW-1:0] dly_q [NSYM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NSYM; j++) dly_q[j] <= '0;
    end else if (tick_i) begin
      dly_q[0] <= sym_i;
      for (int j = 1; j < NSYM; j++) dly_q[j] <= dly_q[j-1];
    end
  end

  // only the nonzero phase of the upsampled stream is computed
  always_comb begin
    shaped_o = '0;
    for (int j = 0; j < NSYM; j++)
      shaped_o = shaped_o + OW'(dly_q[j]) *
                 OW'(shape_tap(j*SPS + int'(ph_i), SPS, NSYM));
  end
endmodule

// File: rtl/qam_mod_tx.sv
`timescale 1ns/1ps
module qam_mod_tx
  import qam_tx_pkg::*;
#(
  parameter int SPS       = 8,
  parameter int NSYM      = 2,
  parameter int PHASE_W   = 16,
  parameter int PHASE_INC = 16384,
  parameter int LUT_BITS  = 6,
  parameter int CAR_W     = 16,
  parameter int OUT_W     = 16,
  parameter int RND_SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_valid_i,
  input  logic                    bit_i,
  output logic                    bit_ready_o,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int PHW  = $clog2(SPS);
  localparam int SHW  = LVL_W + $clog2(SPS+1) + $clog2(NSYM) + 1;
  localparam int PRW  = SHW + CAR_W;
  localparam int SUMW = PRW + 1;
  localparam logic signed [SUMW-1:0] OMAX = SUMW'(2**(OUT_W-1) - 1);
  localparam logic signed [SUMW-1:0] OMIN = -OMAX - 1;
  localparam logic signed [SUMW-1:0] RHALF = SUMW'(1 << (RND_SHIFT-1));

  logic [PHW-1:0]     ph_q;
  logic [PHASE_W-1:0] acc_q;
  logic               tick;
  logic [BITS_PER_SYM-1:0] word;
  logic               word_valid;

  assign tick = (ph_q == PHW'(SPS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      acc_q <= '0;
    end else begin
      ph_q  <= tick ? '0 : ph_q + 1'b1;
      acc_q <= acc_q + PHASE_W'(PHASE_INC);
    end
  end

  qam_bit_packer #(.J(BITS_PER_SYM)) u_packer (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i, .bit_ready_o,
    .sym_tick_i(tick), .word_o(word), .word_valid_o(word_valid)
  );

  logic signed [LVL_W-1:0] lvl   [2];
  logic [LUT_BITS+1:0]     car_ph[2];
  logic signed [SHW-1:0]   shaped[2];
  logic signed [CAR_W-1:0] car   [2];
  logic signed [PRW-1:0]   prod  [2];

  // branch 0: in-phase x cosine, branch 1: quadrature x sine
  for (genvar b = 0; b < 2; b++) begin : g_br
    localparam int MSB = BITS_PER_SYM - 1 - 2*b;
    logic [PHASE_W-1:0] ph_full;
    assign lvl[b]   = word_valid ? axis_level(word[MSB -: 2]) : '0;
    assign ph_full  = (b == 0) ? acc_q + PHASE_W'(1 << (PHASE_W-2)) : acc_q;
    assign car_ph[b] = ph_full[PHASE_W-1 -: LUT_BITS+2];

    qam_polyphase_fir #(.SPS(SPS), .NSYM(NSYM), .SW(LVL_W), .OW(SHW)) u_fir (
      .clk_i, .rst_ni, .tick_i(tick), .sym_i(lvl[b]), .ph_i(ph_q), .shaped_o(shaped[b])
    );

    qam_quarter_sine #(.QB(LUT_BITS), .CW(CAR_W)) u_lut (
      .phase_i(car_ph[b]), .val_o(car[b])
    );

    assign prod[b] = PRW'(shaped[b]) * PRW'(car[b]);
  end

  logic signed [SUMW-1:0] sum, rnd;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    sum = SUMW'(prod[0]) + SUMW'(prod[1]);
    rnd = (sum + RHALF) >>> RND_SHIFT;
    if (rnd > OMAX)      sat = OMAX[OUT_W-1:0];
    else if (rnd < OMIN) sat = OMIN[OUT_W-1:0];
    else                 sat = rnd[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= sat;
  end
endmodule

// File: rtl/qam_mod_tx_chk.sv
`timescale 1ns/1ps
module qam_mod_tx_chk #(
  parameter int J     = 4,
  parameter int SPS   = 8,
  parameter int NSYM  = 2,
  parameter int OUT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    bit_valid_i,
  input logic                    bit_ready_o,
  input logic signed [OUT_W-1:0] sample_o
);
  localparam int DRAIN = (NSYM + 2) * SPS;
  localparam int IW    = $clog2(DRAIN + 1);
  localparam int MW    = $clog2(J);
  localparam int SW    = $clog2(SPS + 1);

  logic          take;
  logic [MW-1:0] mod_q;
  logic          got_word_q;
  logic [IW-1:0] idle_q;
  logic [SW-1:0] stall_q;

  assign take = bit_valid_i && bit_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q      <= '0;
      got_word_q <= 1'b0;
      idle_q     <= '0;
      stall_q    <= '0;
    end else begin
      if (take) begin
        mod_q <= (mod_q == MW'(J-1)) ? '0 : mod_q + 1'b1;
        if (mod_q == MW'(J-1)) got_word_q <= 1'b1;
        idle_q <= '0;
      end else if (idle_q != IW'(DRAIN)) begin
        idle_q <= idle_q + 1'b1;
      end
      stall_q <= bit_ready_o ? '0 : stall_q + 1'b1;
    end
  end

  AST_ZERO_BEFORE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !got_word_q |=> sample_o == '0); // R10
  AST_READY_ONLY_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q != MW'(J-1)) |-> bit_ready_o); // R8
  AST_STALL_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q < SW'(SPS)); // R8
  AST_STARVE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == IW'(DRAIN)) |-> sample_o == '0); // R3
endmodule

bind qam_mod_tx qam_mod_tx_chk #(.J(4), .SPS(SPS), .NSYM(NSYM), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_valid_i(bit_valid_i),
  .bit_ready_o(bit_ready_o), .sample_o(sample_o)
);

// File: tb/qam_mod_tx_bench.sv
`timescale 1ns/1ps
module qam_mod_tx_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0;
  logic bit_ready_o;
  logic signed [15:0] sample_o;

  qam_mod_tx u_qam_mod_tx (.*);

  always #10 clk_i = ~clk_i; // 50 MHz

  int checks = 0, failures = 0;
  bit done = 0;

  // model state (edge count, packer, symbols)
  int e, cnt, pend, pendv, sreg;
  int si[2], sq[2];

  // word bits MSB first, then idle cycles
  localparam logic [7:0] VEC [12] = '{
    {4'b1010, 4'd0}, {4'b1010, 4'd0}, {4'b1010, 4'd0}, {4'b0000, 4'd1},
    {4'b0111, 4'd0}, {4'b1101, 4'd3}, {4'b0110, 4'd9}, {4'b1001, 4'd15},
    {4'b1111, 4'd0}, {4'b0010, 4'd2}, {4'b1000, 4'd0}, {4'b0100, 4'd15}
  };

  function automatic int lvl(input int pair);
    case (pair)
      0: return -3; 1: return -1; 3: return 1; default: return 3;
    endcase
  endfunction

  function automatic int tap(input int k);
    return (k + 1 < 16 - k) ? k + 1 : 16 - k;
  endfunction

  task automatic model_reset();
    e = 0; cnt = 0; pend = 0; pendv = 0; sreg = 0;
    si = '{0, 0}; sq = '{0, 0};
  endtask

  function automatic int exp_ready();
    return !(cnt == 3 && pendv && (e % 8) != 7);
  endfunction

  function automatic int exp_out();
    int p, ci, cq, shi, shq, v, r;
    int cosv[4] = '{32767, 0, -32767, 0};
    int sinv[4] = '{0, 32767, 0, -32767};
    p = e % 8;
    shi = tap(p) * si[0] + tap(8 + p) * si[1];
    shq = tap(p) * sq[0] + tap(8 + p) * sq[1];
    v = shi * cosv[e % 4] + shq * sinv[e % 4];
    r = (v + 4) >>> 3;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_edge(input int take, input int b);
    if (e % 8 == 7) begin
      si[1] = si[0]; sq[1] = sq[0];
      si[0] = pendv ? lvl((pend >> 2) & 3) : 0;
      sq[0] = pendv ? lvl(pend & 3) : 0;
      pendv = 0;
    end
    if (take) begin
      sreg = ((sreg << 1) | b) & 15;
      if (cnt == 3) begin pend = sreg; pendv = 1; cnt = 0; end
      else cnt++;
    end
    e++;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // one cycle; starts and ends at a falling edge
  task automatic step(input logic v, input logic b, output bit took);
    int rdy, eo;
    bit_valid_i = v; bit_i = b;
    #1;
    rdy = exp_ready();
    check(bit_ready_o == rdy[0], "R8 ready", int'(bit_ready_o), rdy);
    eo = exp_out();
    took = v && rdy[0];
    model_edge(int'(took), int'(b));
    @(negedge clk_i);
    check(int'(sample_o) == eo, "R1 R2 R3 R4 R5 R6 R7 R10 sample", int'(sample_o), eo);
  endtask

  task automatic send_word(input logic [3:0] w);
    bit took;
    for (int k = 3; k >= 0; k--) begin
      do step(1'b1, w[k], took); while (!took);
    end
  endtask

  task automatic idle(input int n);
    bit took;
    repeat (n) step(1'b0, 1'b0, took);
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bit_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(sample_o == 0, "R9 reset sample", int'(sample_o), 0);
    check(bit_ready_o == 1'b1, "R9 reset ready", int'(bit_ready_o), 1);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    int sat_hi;
    bit took;
    model_reset();
    apply_reset();
    idle(5);
    // R10: nothing sent, output must stay zero
    check(sample_o == 0, "R10 idle zero", int'(sample_o), 0);

    foreach (VEC[i]) begin
      send_word(VEC[i][7:4]);
      idle(int'(VEC[i][3:0]));
    end
    idle(40);
    check(sample_o == 0, "R3 starved zero", int'(sample_o), 0);

    // R7: three +3/+3 words saturate the cosine phase
    sat_hi = 0;
    send_word(4'b1010); send_word(4'b1010); send_word(4'b1010);
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 1'b0, took);
      if (sample_o == 16'sh7fff) sat_hi++;
    end
    check(sat_hi > 0, "R7 clamp seen", sat_hi, 1);

    // R9: reset in mid-word drops the partial bits
    step(1'b1, 1'b1, took); step(1'b1, 1'b0, took);
    apply_reset();
    idle(3);
    send_word(4'b0111);
    idle(40);
    check(sample_o == 0, "R1 R9 drained", int'(sample_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule